// File: doc/BRIEF.md
# Staged Time-Base Watchdog

This block watches one tap bit of a shared, free-running 64-bit time base. Each time that bit rises from 0 to 1, the block records a timeout. Timeouts do not act at once. Each one moves a small status register one stage further. The first timeout arms the watchdog. The second raises an interrupt request. The third asks for a reset of the kind that software chose. Software keeps the watchdog quiet by clearing the status bits before the next tap edge, and it clears them by writing ones.

The tap is taken from a control register. In extended mode, a 2-bit period field and a 4-bit extension form a 6-bit value, and the tap position is 63 minus that value, so any bit of the time base can be chosen. In table mode, the 2-bit period field selects one of four tap positions that are fixed by a parameter. A pulse on the debug-resume input clears the whole stage state, so that time spent halted cannot lead to a reset. The time base, the interrupt controller and the reset logic are outside the block.

Top module: `tap_watchdog`

## Requirements
- R1: After reset, the control readback, the status readback, `wd_irq_o` and `rst_req_o` are all zero.
- R2: A control write takes effect on the next clock and is read back with these fields: period in bits 31:30, reset code in bits 29:28, interrupt enable in bit 27, and period extension in bits 20:17. Every other readback bit is 0, whatever was written there.
- R3: With `EXT_MODE`=1, the watched tap is bit 63 − {extension, period}, where the extension is the upper four bits of the 6-bit value. With both fields at zero this is bit 63, and with both at all-ones it is bit 0.
- R4: With `EXT_MODE`=0, the watched tap is entry `period` of `TAP_TABLE`, where entry i occupies bits 6i+5:6i.
- R5: A timeout happens only in a cycle where the watched bit is 1 and the same bit was 0 on the previous cycle. A falling edge, a change in any other bit, or a bit that stays high produces no timeout.
- R6: On a timeout while the arm bit (status bit 31) is 0, the arm bit is set on the next clock.
- R7: On a timeout while the arm bit is 1 and the interrupt-pending bit (status bit 30) is 0, the interrupt-pending bit is set.
- R8: On a timeout while both bits are 1 and the control reset code is nonzero, the code is copied into status bits 29:28, and `rst_req_o` carries the code for exactly one cycle. If the code is 0, nothing changes.
- R9: A status write clears each of the bits 31:28 whose written bit is 1 and keeps the others. Without a write, a resume or a timeout, the status holds its value.
- R10: `wd_irq_o` is high exactly when the interrupt-pending bit and the control interrupt enable are both 1.
- R11: A `dbg_resume_i` pulse clears the arm bit, the interrupt-pending bit and the reset-status field.
- R12: When a clear (a write or a resume) and a timeout fall in the same cycle, the clear is applied to the old status, the stage step is chosen from the old status, and a bit that the step sets ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase_i | input | TB_W | Free-running time-base value |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write data |
| sts_wr_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | 32 | Status clear mask |
| dbg_resume_i | input | 1 | Resume-from-debug pulse |
| ctl_q_o | output | 32 | Control register readback |
| sts_q_o | output | 32 | Status register readback |
| wd_irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 2 | Reset request, one-cycle pulse carrying the code |

## Verification
The bench builds two copies side by side on the same inputs. One copy uses `EXT_MODE`=1. The other uses `EXT_MODE`=0 with a table of taps 8, 12, 16 and 20, so both ways of choosing a tap are covered. The bench drives the time base directly rather than letting it count. This makes the extreme taps 63 and 0 and the middle tap 50 reachable within a few cycles. It also lets edges on the table taps be placed one at a time, so both copies can be stepped through all three stages independently.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Field positions are software-visible and decoded by neighbours
  localparam int CTL_PER_LSB  = 30;
  localparam int CTL_RC_LSB   = 28;
  localparam int CTL_IE_BIT   = 27;
  localparam int CTL_EXT_LSB  = 17;
  localparam int STS_ARM_BIT  = 31;
  localparam int STS_PEND_BIT = 30;
  localparam int STS_RC_LSB   = 28;

  typedef struct packed {
    logic [1:0] per;
    logic [1:0] rcode;
    logic       irq_en;
    logic [3:0] per_ext;
  } wdt_ctl_t;

  typedef struct packed {
    logic       armed;
    logic       irq_pend;
    logic [1:0] rst_code;
  } wdt_sts_t;

  function automatic wdt_ctl_t ctl_unpack(input logic [31:0] d);
    wdt_ctl_t c;
    c.per     = d[CTL_PER_LSB +: 2];
    c.rcode   = d[CTL_RC_LSB +: 2];
    c.irq_en  = d[CTL_IE_BIT];
    c.per_ext = d[CTL_EXT_LSB +: 4];
    return c;
  endfunction

  function automatic logic [31:0] ctl_pack(input wdt_ctl_t c);
    logic [31:0] d;
    d = '0;
    d[CTL_PER_LSB +: 2]  = c.per;
    d[CTL_RC_LSB +: 2]   = c.rcode;
    d[CTL_IE_BIT]        = c.irq_en;
    d[CTL_EXT_LSB +: 4]  = c.per_ext;
    return d;
  endfunction

  function automatic logic [31:0] sts_pack(input wdt_sts_t s);
    logic [31:0] d;
    d = '0;
    d[STS_ARM_BIT]      = s.armed;
    d[STS_PEND_BIT]     = s.irq_pend;
    d[STS_RC_LSB +: 2]  = s.rst_code;
    return d;
  endfunction

  // Mask of status bits named by a write-one-to-clear access
  function automatic wdt_sts_t sts_clear_mask(input logic [31:0] d);
    wdt_sts_t m;
    m.armed    = d[STS_ARM_BIT];
    m.irq_pend = d[STS_PEND_BIT];
    m.rst_code = d[STS_RC_LSB +: 2];
    return m;
  endfunction

  // Extended tap: counted down from the top bit of a 64-bit time base
  function automatic logic [5:0] ext_tap(input logic [1:0] per, input logic [3:0] ext);
    return 6'd63 - {ext, per};
  endfunction

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output wdt_ctl_t    ctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr) begin
      ctl <= ctl_unpack(wdata);
    end
  end

endmodule

// File: rtl/wdt_tap_edge.sv
module wdt_tap_edge
  import wdt_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter bit EXT_MODE = 1'b1,
  parameter logic [4*$clog2(TB_W)-1:0] TAP_TABLE = {6'd41, 6'd37, 6'd33, 6'd29}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TB_W-1:0]          tbase,
  input  wdt_ctl_t                 ctl,
  output logic [$clog2(TB_W)-1:0]  tap_idx,
  output logic                     tap_now,
  output logic                     tap_was,
  output logic                     timeout_evt
);

  localparam int TAP_W = $clog2(TB_W);

  logic [TB_W-1:0] tb_prev;

  generate
    if (EXT_MODE) begin : g_ext
      assign tap_idx = TAP_W'(ext_tap(ctl.per, ctl.per_ext));
    end else begin : g_tbl
      logic [3:0] unused_ext;
      assign unused_ext = ctl.per_ext;
      assign tap_idx = TAP_TABLE[ctl.per*TAP_W +: TAP_W];
    end
  endgenerate

  // Whole previous word kept so a tap change never fakes an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_prev <= '0;
    else        tb_prev <= tbase;
  end

  assign tap_now     = tbase[tap_idx];
  assign tap_was     = tb_prev[tap_idx];
  assign timeout_evt = tap_now & ~tap_was;

endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        timeout_evt,
  input  logic [1:0]  rcode,
  input  logic        sts_wr,
  input  logic [31:0] sts_wdata,
  input  logic        dbg_resume,
  output wdt_sts_t    sts,
  output logic        adv_arm,
  output logic        adv_pend,
  output logic        adv_rst,
  output logic [1:0]  rst_req
);

  wdt_sts_t clr;
  wdt_sts_t kept;
  wdt_sts_t nxt;

  always_comb begin
    clr = sts_wr ? sts_clear_mask(sts_wdata) : '0;
    if (dbg_resume) begin
      clr.armed    = 1'b1;
      clr.irq_pend = 1'b1;
      clr.rst_code = 2'b11;
    end
  end

  assign kept = wdt_sts_t'(sts & ~clr);

  // Stage step is decided from the status before this cycle's clears
  assign adv_arm  = timeout_evt & ~sts.armed;
  assign adv_pend = timeout_evt &  sts.armed & ~sts.irq_pend;
  assign adv_rst  = timeout_evt &  sts.armed &  sts.irq_pend & (rcode != 2'b00);

  always_comb begin
    nxt = kept;
    if (adv_arm)  nxt.armed    = 1'b1;
    if (adv_pend) nxt.irq_pend = 1'b1;
    if (adv_rst)  nxt.rst_code = rcode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      rst_req <= 2'b00;
    end else begin
      sts     <= nxt;
      rst_req <= adv_rst ? rcode : 2'b00;
    end
  end

endmodule

// File: rtl/tap_watchdog.sv
module tap_watchdog
  import wdt_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter bit EXT_MODE = 1'b1,
  parameter logic [4*$clog2(TB_W)-1:0] TAP_TABLE = {6'd41, 6'd37, 6'd33, 6'd29}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tbase_i,
  input  logic            ctl_wr_i,
  input  logic [31:0]     ctl_wdata_i,
  input  logic            sts_wr_i,
  input  logic [31:0]     sts_wdata_i,
  input  logic            dbg_resume_i,
  output logic [31:0]     ctl_q_o,
  output logic [31:0]     sts_q_o,
  output logic            wd_irq_o,
  output logic [1:0]      rst_req_o
);

  localparam int TAP_W = $clog2(TB_W);

  wdt_ctl_t         ctl;
  wdt_sts_t         sts;
  logic [TAP_W-1:0] tap_idx;
  logic             tap_now;
  logic             tap_was;
  logic             timeout_evt;
  logic             adv_arm;
  logic             adv_pend;
  logic             adv_rst;

  wdt_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr_i),
    .wdata (ctl_wdata_i),
    .ctl   (ctl)
  );

  wdt_tap_edge #(
    .TB_W      (TB_W),
    .EXT_MODE  (EXT_MODE),
    .TAP_TABLE (TAP_TABLE)
  ) u_tap (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbase       (tbase_i),
    .ctl         (ctl),
    .tap_idx     (tap_idx),
    .tap_now     (tap_now),
    .tap_was     (tap_was),
    .timeout_evt (timeout_evt)
  );

  wdt_stage_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .timeout_evt (timeout_evt),
    .rcode       (ctl.rcode),
    .sts_wr      (sts_wr_i),
    .sts_wdata   (sts_wdata_i),
    .dbg_resume  (dbg_resume_i),
    .sts         (sts),
    .adv_arm     (adv_arm),
    .adv_pend    (adv_pend),
    .adv_rst     (adv_rst),
    .rst_req     (rst_req_o)
  );

  logic unused_dbg;
  assign unused_dbg = ^{tap_idx, tap_now, tap_was, adv_arm, adv_pend, adv_rst};

  assign ctl_q_o  = ctl_pack(ctl);
  assign sts_q_o  = sts_pack(sts);
  assign wd_irq_o = sts.irq_pend & ctl.irq_en;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        timeout_evt,
  input logic        dbg_resume,
  input logic        sts_wr,
  input logic [31:0] sts_wdata,
  input logic [31:0] sts_q,
  input logic [31:0] ctl_q,
  input logic        wd_irq,
  input logic [1:0]  rst_req
);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> (sts_q[30] && ctl_q[27]));

  p_rst_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != 2'b00) |-> (sts_q[29:28] == rst_req));

  p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != 2'b00) |-> $past(sts_q[31] && sts_q[30] && timeout_evt));

  p_arm_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && !sts_q[31]) |=> sts_q[31]);

  p_w1c_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata[30] && !timeout_evt) |=> !sts_q[30]);

  p_resume_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_resume && !timeout_evt) |=> (sts_q[31:28] == 4'b0000));

  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout_evt && !sts_wr && !dbg_resume) |=> $stable(sts_q[31:28]));

endmodule

bind tap_watchdog wdt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .timeout_evt (timeout_evt),
  .dbg_resume  (dbg_resume_i),
  .sts_wr      (sts_wr_i),
  .sts_wdata   (sts_wdata_i),
  .sts_q       (sts_q_o),
  .ctl_q       (ctl_q_o),
  .wd_irq      (wd_irq_o),
  .rst_req     (rst_req_o)
);

// File: tb/test_tap_watchdog.sv
module test_tap_watchdog;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tbase = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        sts_wr = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic        resume = 1'b0;

  logic [31:0] ctl_a, sts_a, ctl_b, sts_b;
  logic        irq_a, irq_b;
  logic [1:0]  rr_a, rr_b;

  always #5 clk = ~clk;

  tap_watchdog #(.TB_W(64), .EXT_MODE(1'b1)) i_tap_watchdog (
    .clk(clk), .rst_n(rst_n), .tbase_i(tbase),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata), .dbg_resume_i(resume),
    .ctl_q_o(ctl_a), .sts_q_o(sts_a), .wd_irq_o(irq_a), .rst_req_o(rr_a)
  );

  tap_watchdog #(.TB_W(64), .EXT_MODE(1'b0),
                 .TAP_TABLE({6'd20, 6'd16, 6'd12, 6'd8})) i_tap_watchdog_tbl (
    .clk(clk), .rst_n(rst_n), .tbase_i(tbase),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata), .dbg_resume_i(resume),
    .ctl_q_o(ctl_b), .sts_q_o(sts_b), .wd_irq_o(irq_b), .rst_req_o(rr_b)
  );

  typedef struct {
    string       tag;
    logic [31:0] ctl;
    logic [31:0] sa, sb;
    logic        ia, ib;
    logic [1:0]  ra, rb;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference state, kept in the bench's own terms
  logic [1:0]  m_wp, m_wrc, m_ext_lo;
  logic [3:0]  m_ext;
  logic        m_wie;
  logic        m_en[2], m_wi[2];
  logic [1:0]  m_ws[2];
  logic [63:0] m_prev;
  int          tbl_taps[4] = '{8, 12, 16, 20};

  function automatic logic [31:0] mkctl(input logic [1:0] wp, input logic [1:0] wrc,
                                        input logic wie, input logic [3:0] ext);
    return {wp, wrc, wie, 6'b0, ext, 17'b0};
  endfunction

  function automatic logic [31:0] mksts(input logic en, input logic wi, input logic [1:0] ws);
    return {en, wi, ws, 28'b0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input bit cw, input logic [31:0] cd, input bit sw,
                      input logic [31:0] sd, input bit rs, input logic [63:0] tb,
                      input string tag);
    exp_t e;
    logic [1:0] rr[2];
    @(negedge clk);
    ctl_wr = cw; ctl_wdata = cd; sts_wr = sw; sts_wdata = sd; resume = rs; tbase = tb;
    for (int k = 0; k < 2; k++) begin
      int  tap;
      bit  evt;
      logic oen, owi;
      tap = (k == 0) ? (63 - (int'(m_ext) * 4 + int'(m_wp))) : tbl_taps[m_wp];
      evt = tb[tap] && !m_prev[tap];
      oen = m_en[k]; owi = m_wi[k];
      if (sw) begin
        if (sd[31]) m_en[k] = 1'b0;
        if (sd[30]) m_wi[k] = 1'b0;
        m_ws[k] = m_ws[k] & ~sd[29:28];
      end
      if (rs) begin
        m_en[k] = 1'b0; m_wi[k] = 1'b0; m_ws[k] = 2'b00;
      end
      rr[k] = 2'b00;
      if (evt) begin
        if (!oen)                 m_en[k] = 1'b1;
        else if (!owi)            m_wi[k] = 1'b1;
        else if (m_wrc != 2'b00) begin m_ws[k] = m_wrc; rr[k] = m_wrc; end
      end
    end
    if (cw) begin
      m_wp = cd[31:30]; m_wrc = cd[29:28]; m_wie = cd[27]; m_ext = cd[20:17];
    end
    m_prev = tb;
    e.tag = tag;
    e.ctl = mkctl(m_wp, m_wrc, m_wie, m_ext);
    e.sa  = mksts(m_en[0], m_wi[0], m_ws[0]);
    e.sb  = mksts(m_en[1], m_wi[1], m_ws[1]);
    e.ia  = m_wi[0] && m_wie;
    e.ib  = m_wi[1] && m_wie;
    e.ra  = rr[0];
    e.rb  = rr[1];
    q.push_back(e);
  endtask

  task automatic tbv(input logic [63:0] tb, input string tag);
    step(0, '0, 0, '0, 0, tb, tag);
  endtask

  // Monitor: compare one expected item per clock
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (ctl_a !== e.ctl || ctl_b !== e.ctl || sts_a !== e.sa || sts_b !== e.sb ||
            irq_a !== e.ia || irq_b !== e.ib || rr_a !== e.ra || rr_b !== e.rb) begin
          n_bad++;
          $display("FAIL %s: act ctl=%h/%h sts=%h/%h irq=%b/%b rr=%b/%b exp ctl=%h sts=%h/%h irq=%b/%b rr=%b/%b",
                   e.tag, ctl_a, ctl_b, sts_a, sts_b, irq_a, irq_b, rr_a, rr_b,
                   e.ctl, e.sa, e.sb, e.ia, e.ib, e.ra, e.rb);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: act run unfinished exp finished");
    finish_run();
  end

  initial begin
    m_wp = '0; m_wrc = '0; m_wie = 1'b0; m_ext = '0; m_ext_lo = '0; m_prev = '0;
    for (int k = 0; k < 2; k++) begin m_en[k] = 1'b0; m_wi[k] = 1'b0; m_ws[k] = 2'b00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (ctl_a !== 0 || ctl_b !== 0 || sts_a !== 0 || sts_b !== 0 ||
        irq_a !== 0 || irq_b !== 0 || rr_a !== 0 || rr_b !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: act ctl=%h sts=%h/%h irq=%b rr=%b exp all zero",
               ctl_a, sts_a, sts_b, irq_a, rr_a);
    end
    tbv(64'h0, "R1 idle");
    // R3: default fields select bit 63 in extended mode
    tbv(64'h8000_0000_0000_0000, "R3 tap63 arms R6");
    tbv(64'h0, "R5 falling ignored");
    // R2: junk bits 26 and 0 must not read back
    step(1, mkctl(2'd1, 2'd2, 1'b1, 4'd3) | 32'h0400_0001, 0, '0, 0, 64'h0, "R2 ctl write");
    // Extended tap now 63-13=50, table tap 12
    tbv(64'h0004_0000_0000_0000, "R3 tap50 R7 R10 pend");
    tbv(64'h0, "R5 falling ignored");
    tbv(64'h0008_0000_0000_0000, "R5 other bit ignored");
    tbv(64'h000C_0000_0000_0000, "R8 tap50 reset code");
    tbv(64'h000C_0000_0000_0000, "R8 single pulse R5 level");
    tbv(64'h000C_0000_0000_0000, "R5 level held");
    tbv(64'h0, "R5 idle");
    tbv(64'h0000_0000_0000_1000, "R4 table tap12 arm");
    tbv(64'h0, "R4 fall");
    tbv(64'h0000_0000_0000_1000, "R4 table pend");
    tbv(64'h0, "R4 fall");
    tbv(64'h0000_0000_0000_1000, "R4 table reset R8");
    tbv(64'h0000_0000_0000_0800, "R5 neighbour bit");
    step(0, '0, 1, 32'h4000_0000, 0, 64'h0, "R9 clear pend only R10");
    step(0, '0, 1, 32'h1000_0000, 0, 64'h0, "R9 clear code low bit");
    tbv(64'h0, "R9 hold");
    step(0, '0, 0, '0, 1, 64'h0, "R11 resume clears");
    // R3: all-ones fields select bit 0; reset code 0 suppresses stage three
    step(1, mkctl(2'd3, 2'd0, 1'b1, 4'hF), 0, '0, 0, 64'h0, "R2 ctl tap0");
    tbv(64'h1, "R3 tap0 arm");
    tbv(64'h0, "R5 fall");
    tbv(64'h1, "R7 tap0 pend R10");
    tbv(64'h0, "R5 fall");
    tbv(64'h1, "R8 zero code no reset");
    tbv(64'h0, "R8 idle");
    tbv(64'h0000_0000_0010_0000, "R4 table tap20 arm");
    step(0, '0, 0, '0, 1, 64'h0, "R11 resume");
    // R12: clear of the arm bit in the same cycle as an arming edge
    step(0, '0, 1, 32'hF000_0000, 0, 64'h1, "R12 set beats clear");
    tbv(64'h0, "R12 fall");
    step(0, '0, 0, '0, 1, 64'h1, "R12 resume with pend step");
    tbv(64'h0, "R12 idle");
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule